// File: doc/BRIEF.md
# Flash Byte Program Sequencer

This block sits on the host side of a parallel, command-driven flash device and programs one byte at a time with a bounded pulse-and-verify loop. A requester presents a 17-bit address and an 8-bit value. The sequencer then drives the flash bus through a fixed order of bus cycles for each attempt:

- a write of the program command;
- a write that carries the target address and the value;
- a program pulse of fixed length, ended by the rising write-enable edge of a verify-command write;
- a recovery wait;
- a read-back.

If the read-back value equals the requested value, the byte passes. If it does not, the sequencer starts another attempt. After a fixed number of attempts without a match, the byte fails. In either case the sequencer writes the read-mode command before it reports the result, together with the number of attempts it used.

The bus-level timing is set entirely by clock-count parameters: the setup before a strobe, the strobe width, the hold after it, the read strobe length, the program pulse and the recovery wait. The flash data bus is split into an output, an output enable and an input, so that the surrounding pad logic can build the bidirectional pin. The requester sees a single-cycle accept (valid while ready) and a single-cycle completion strobe. The completion strobe carries a pass flag and the attempt count.

Top module: `fps_program_seq`

## Requirements
- R1: While reset is asserted and directly after it, chip enable, write enable and output enable are high (inactive), the data output enable is 0, ready is 1 and done is 0.
- R2: Every attempt begins with a write cycle carrying 8'h40, followed immediately by a write cycle that carries the requested address and data; the address is on the bus when write enable falls and when it rises.
- R3: In every write cycle write enable stays low for WP_CYC clock cycles. Address and data are stable while it is low and are still driven, with chip enable low, on the cycle write enable returns high.
- R4: At least PULSE_CYC clock cycles pass between the rising write-enable edge of the data write and the rising write-enable edge of the following verify-command write.
- R5: Each attempt's verify is a write of 8'hC0 followed by a read. At least RECOV_CYC clock cycles pass between the rising write-enable edge of that write and the fall of output enable. The data output enable is 0 whenever output enable is low.
- R6: When the read-back value equals the requested data, the request completes with pass=1, and attempts equals the number of attempts made.
- R7: When the read-back value differs, a new attempt starts with 8'h40, until MAX_TRIES attempts have been made. A byte still unmatched after MAX_TRIES attempts completes with pass=0 and attempts=MAX_TRIES. attempts never exceeds MAX_TRIES.
- R8: After the last verify, a write of 8'h00 is issued before done. done is a single-cycle strobe. ready is 0 from acceptance until after done and is 1 in the cycle after done.
- R9: A request presented while ready is 0 is ignored: it does not change the byte being programmed and does not start a later operation.
- R10: Write enable and output enable are never low together, and chip enable is low whenever either of them is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Program request; accepted when ready_o is 1 |
| req_addr_i | input | 17 | Byte address to program |
| req_data_i | input | 8 | Value to program |
| ready_o | output | 1 | Sequencer idle and able to accept a request |
| done_o | output | 1 | Single-cycle completion strobe |
| pass_o | output | 1 | Result of the last request: 1 = verified, 0 = gave up |
| attempts_o | output | 5 | Attempts used by the last request |
| fl_ce_n_o | output | 1 | Flash chip enable, active low |
| fl_we_n_o | output | 1 | Flash write enable, active low |
| fl_oe_n_o | output | 1 | Flash output enable, active low |
| fl_addr_o | output | 17 | Flash address bus |
| fl_dq_o | output | 8 | Flash data bus, outgoing value |
| fl_dq_oe_o | output | 1 | Drive enable for fl_dq_o |
| fl_dq_i | input | 8 | Flash data bus, incoming value |

## Verification
The assertions watch the bus protocol on every cycle. They check that write enable and output enable never overlap and that chip enable frames both strobes. They check that the data driver is off during reads and that address and data are stable through each write strobe and its rising edge. They also check that the held request does not move while the sequencer is busy, that ready follows done, and that the attempt count stays within its cap.

Only the bench's flash model can show the parts that depend on the whole command order and on elapsed time. These are:
- the 40H/data/C0H/00H sequence;
- the minimum program-pulse and recovery gaps;
- the exact attempt count against a device that needs a chosen number of pulses, including exactly MAX_TRIES and one more;
- that a request presented mid-operation leaves no trace.

// File: rtl/fps_pkg.sv
package fps_pkg;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_SETUP,
      PH_STROBE,
      PH_HOLD
   } bus_phase_t;

   typedef enum logic [3:0] {
      S_IDLE,
      S_PROG_CMD,
      S_PROG_DATA,
      S_PULSE,
      S_VFY_CMD,
      S_RECOV,
      S_VFY_READ,
      S_CHECK,
      S_RESTORE,
      S_REPORT
   } seq_state_t;

   localparam logic [7:0] CMD_PROGRAM = 8'h40;
   localparam logic [7:0] CMD_VERIFY  = 8'hC0;
   localparam logic [7:0] CMD_READ    = 8'h00;

endpackage

// File: rtl/fps_timer.sv
module fps_timer #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] val_i,
   output logic         expired_o
);

   logic [W-1:0] cnt;

   generate
      if (W < 1) begin : g_bad_w
         $error("fps_timer: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)           cnt <= '0;
      else if (load_i)      cnt <= val_i;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign expired_o = (cnt == '0) && !load_i;

endmodule

// File: rtl/fps_bus_cycle.sv
module fps_bus_cycle
   import fps_pkg::*;
#(
   parameter int ADDR_W    = 17,
   parameter int DATA_W    = 8,
   parameter int SETUP_CYC = 2,
   parameter int WP_CYC    = 5,
   parameter int HOLD_CYC  = 4,
   parameter int READ_CYC  = 10,
   parameter int IN_STAGES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_i,
   input  logic              rd_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              done_o,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              ce_n_o,
   output logic              we_n_o,
   output logic              oe_n_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] dq_o,
   output logic              dq_oe_o,
   input  logic [DATA_W-1:0] dq_i
);

   localparam int M1   = (SETUP_CYC > WP_CYC) ? SETUP_CYC : WP_CYC;
   localparam int M2   = (HOLD_CYC > READ_CYC) ? HOLD_CYC : READ_CYC;
   localparam int LONG = (M1 > M2) ? M1 : M2;
   localparam int CW   = $clog2(LONG + 1);

   generate
      if (SETUP_CYC < 1 || WP_CYC < 1 || HOLD_CYC < 1) begin : g_bad_wr
         $error("fps_bus_cycle: write phases need at least one cycle each");
      end
      if (READ_CYC < IN_STAGES + 1) begin : g_bad_rd
         $error("fps_bus_cycle: READ_CYC must exceed IN_STAGES");
      end
   endgenerate

   // Optional input capture stages on the incoming data bus
   logic [DATA_W-1:0] dq_s;
   generate
      if (IN_STAGES == 0) begin : g_sync_none
         assign dq_s = dq_i;
      end else begin : g_sync
         logic [DATA_W-1:0] pipe [IN_STAGES];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < IN_STAGES; i++) pipe[i] <= '0;
            end else begin
               pipe[0] <= dq_i;
               for (int i = 1; i < IN_STAGES; i++) pipe[i] <= pipe[i-1];
            end
         end
         assign dq_s = pipe[IN_STAGES-1];
      end
   endgenerate

   bus_phase_t    ph;
   logic [CW-1:0] cnt;
   logic          rd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph        <= PH_IDLE;
         cnt       <= '0;
         rd_q      <= 1'b0;
         ce_n_o    <= 1'b1;
         we_n_o    <= 1'b1;
         oe_n_o    <= 1'b1;
         addr_o    <= '0;
         dq_o      <= '0;
         dq_oe_o   <= 1'b0;
         rd_data_o <= '0;
         done_o    <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (ph)
            PH_IDLE: begin
               if (go_i) begin
                  ph      <= PH_SETUP;
                  cnt     <= CW'(SETUP_CYC - 1);
                  rd_q    <= rd_i;
                  ce_n_o  <= 1'b0;
                  addr_o  <= addr_i;
                  dq_o    <= data_i;
                  dq_oe_o <= !rd_i;
               end
            end
            PH_SETUP: begin
               if (cnt == '0) begin
                  ph <= PH_STROBE;
                  if (rd_q) begin
                     cnt    <= CW'(READ_CYC - 1);
                     oe_n_o <= 1'b0;
                  end else begin
                     cnt    <= CW'(WP_CYC - 1);
                     we_n_o <= 1'b0;
                  end
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_STROBE: begin
               if (cnt == '0) begin
                  ph     <= PH_HOLD;
                  cnt    <= CW'(HOLD_CYC - 1);
                  we_n_o <= 1'b1;
                  oe_n_o <= 1'b1;
                  if (rd_q) rd_data_o <= dq_s;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_HOLD: begin
               if (cnt == '0) begin
                  ph      <= PH_IDLE;
                  ce_n_o  <= 1'b1;
                  dq_oe_o <= 1'b0;
                  done_o  <= 1'b1;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

   assert_we_oe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(!we_n_o && !oe_n_o));

   assert_ce_frames_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!we_n_o || !oe_n_o) |-> !ce_n_o);

   assert_no_drive_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n_o |-> !dq_oe_o);

   assert_stable_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!we_n_o && !$past(we_n_o)) |-> ($stable(addr_o) && $stable(dq_o)));

   assert_hold_at_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n_o) |-> (!ce_n_o && dq_oe_o && $stable(addr_o) && $stable(dq_o)));

endmodule

// File: rtl/fps_program_seq.sv
module fps_program_seq
   import fps_pkg::*;
#(
   parameter int ADDR_W    = 17,
   parameter int DATA_W    = 8,
   parameter int MAX_TRIES = 25,
   parameter int PULSE_CYC = 1000,
   parameter int RECOV_CYC = 600,
   parameter int SETUP_CYC = 2,
   parameter int WP_CYC    = 5,
   parameter int HOLD_CYC  = 4,
   parameter int READ_CYC  = 10,
   parameter int IN_STAGES = 1,
   localparam int TRY_W    = $clog2(MAX_TRIES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [DATA_W-1:0] req_data_i,
   output logic              ready_o,
   output logic              done_o,
   output logic              pass_o,
   output logic [TRY_W-1:0]  attempts_o,
   output logic              fl_ce_n_o,
   output logic              fl_we_n_o,
   output logic              fl_oe_n_o,
   output logic [ADDR_W-1:0] fl_addr_o,
   output logic [DATA_W-1:0] fl_dq_o,
   output logic              fl_dq_oe_o,
   input  logic [DATA_W-1:0] fl_dq_i
);

   localparam int TMAX = (PULSE_CYC > RECOV_CYC) ? PULSE_CYC : RECOV_CYC;
   localparam int TW   = $clog2(TMAX + 1);

   generate
      if (DATA_W < 8)
         begin : g_bad_dw   $error("fps_program_seq: DATA_W must hold a command byte"); end
      if (MAX_TRIES < 1)
         begin : g_bad_try  $error("fps_program_seq: MAX_TRIES must be at least 1"); end
      if (PULSE_CYC < 1 || RECOV_CYC < 1)
         begin : g_bad_time $error("fps_program_seq: pulse and recovery need at least one cycle"); end
   endgenerate

   seq_state_t        state, state_n;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic [TRY_W-1:0]  try_cnt;
   logic              pass_q;

   // registered launch controls for the bus engine and timer
   logic              go_q, go_n;
   logic              rd_q, rd_n;
   logic [DATA_W-1:0] bdat_q, bdat_n;
   logic              ld_q, ld_n;
   logic [TW-1:0]     tval_q, tval_n;
   logic              accept, inc_try, set_pass;

   logic              cyc_done;
   logic [DATA_W-1:0] rd_data;
   logic              tmr_exp;

   fps_bus_cycle #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .SETUP_CYC(SETUP_CYC),
      .WP_CYC   (WP_CYC),
      .HOLD_CYC (HOLD_CYC),
      .READ_CYC (READ_CYC),
      .IN_STAGES(IN_STAGES)
   ) u_bus (
      .clk      (clk),
      .rst_n    (rst_n),
      .go_i     (go_q),
      .rd_i     (rd_q),
      .addr_i   (addr_q),
      .data_i   (bdat_q),
      .done_o   (cyc_done),
      .rd_data_o(rd_data),
      .ce_n_o   (fl_ce_n_o),
      .we_n_o   (fl_we_n_o),
      .oe_n_o   (fl_oe_n_o),
      .addr_o   (fl_addr_o),
      .dq_o     (fl_dq_o),
      .dq_oe_o  (fl_dq_oe_o),
      .dq_i     (fl_dq_i)
   );

   fps_timer #(.W(TW)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (ld_q),
      .val_i    (tval_q),
      .expired_o(tmr_exp)
   );

   always_comb begin
      state_n  = state;
      go_n     = 1'b0;
      rd_n     = 1'b0;
      bdat_n   = data_q;
      ld_n     = 1'b0;
      tval_n   = '0;
      accept   = 1'b0;
      inc_try  = 1'b0;
      set_pass = 1'b0;
      unique case (state)
         S_IDLE: if (req_valid_i) begin
            accept  = 1'b1;
            state_n = S_PROG_CMD;
            go_n    = 1'b1;
            bdat_n  = DATA_W'(CMD_PROGRAM);
         end
         S_PROG_CMD: if (cyc_done) begin
            state_n = S_PROG_DATA;
            go_n    = 1'b1;
            bdat_n  = data_q;
         end
         S_PROG_DATA: if (cyc_done) begin
            state_n = S_PULSE;
            ld_n    = 1'b1;
            tval_n  = TW'(PULSE_CYC);
         end
         S_PULSE: if (tmr_exp) begin
            state_n = S_VFY_CMD;
            go_n    = 1'b1;
            bdat_n  = DATA_W'(CMD_VERIFY);
         end
         S_VFY_CMD: if (cyc_done) begin
            state_n = S_RECOV;
            ld_n    = 1'b1;
            tval_n  = TW'(RECOV_CYC);
         end
         S_RECOV: if (tmr_exp) begin
            state_n = S_VFY_READ;
            go_n    = 1'b1;
            rd_n    = 1'b1;
         end
         S_VFY_READ: if (cyc_done) state_n = S_CHECK;
         S_CHECK: begin
            go_n = 1'b1;
            if (rd_data == data_q) begin
               set_pass = 1'b1;
               state_n  = S_RESTORE;
               bdat_n   = DATA_W'(CMD_READ);
            end else if (try_cnt == TRY_W'(MAX_TRIES)) begin
               state_n  = S_RESTORE;
               bdat_n   = DATA_W'(CMD_READ);
            end else begin
               inc_try  = 1'b1;
               state_n  = S_PROG_CMD;
               bdat_n   = DATA_W'(CMD_PROGRAM);
            end
         end
         S_RESTORE: if (cyc_done) state_n = S_REPORT;
         S_REPORT:  state_n = S_IDLE;
         default:   state_n = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         addr_q  <= '0;
         data_q  <= '0;
         try_cnt <= '0;
         pass_q  <= 1'b0;
         go_q    <= 1'b0;
         rd_q    <= 1'b0;
         bdat_q  <= '0;
         ld_q    <= 1'b0;
         tval_q  <= '0;
      end else begin
         state  <= state_n;
         go_q   <= go_n;
         rd_q   <= rd_n;
         bdat_q <= bdat_n;
         ld_q   <= ld_n;
         tval_q <= tval_n;
         if (accept) begin
            addr_q  <= req_addr_i;
            data_q  <= req_data_i;
            try_cnt <= TRY_W'(1);
            pass_q  <= 1'b0;
         end else begin
            if (inc_try)  try_cnt <= try_cnt + 1'b1;
            if (set_pass) pass_q  <= 1'b1;
         end
      end
   end

   assign ready_o    = (state == S_IDLE);
   assign done_o     = (state == S_REPORT);
   assign pass_o     = pass_q;
   assign attempts_o = try_cnt;

   assert_ready_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> ready_o);

   assert_attempt_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      try_cnt <= TRY_W'(MAX_TRIES));

   assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !ready_o |=> ($stable(addr_q) && $stable(data_q)));

   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

endmodule

// File: tb/tb_fps_program_seq.sv
module tb_fps_program_seq;

   localparam int AW    = 17;
   localparam int DW    = 8;
   localparam int TRIES = 25;
   localparam int PULSE = 100;
   localparam int RECOV = 60;
   localparam int WP    = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_data = '0;
   logic          ready, done, pass;
   logic [4:0]    attempts;
   logic          ce_n, we_n, oe_n, dq_oe;
   logic [AW-1:0] fl_addr;
   logic [DW-1:0] dq_out, dq_in;

   always #5 clk = ~clk;

   fps_program_seq #(
      .MAX_TRIES(TRIES), .PULSE_CYC(PULSE), .RECOV_CYC(RECOV), .WP_CYC(WP)
   ) dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid_i(req_valid), .req_addr_i(req_addr), .req_data_i(req_data),
      .ready_o(ready), .done_o(done), .pass_o(pass), .attempts_o(attempts),
      .fl_ce_n_o(ce_n), .fl_we_n_o(we_n), .fl_oe_n_o(oe_n),
      .fl_addr_o(fl_addr), .fl_dq_o(dq_out), .fl_dq_oe_o(dq_oe), .fl_dq_i(dq_in)
   );

   // ---------------- flash device model ----------------
   logic          m_clr = 1'b0;
   int            m_need = 1;
   logic [AW-1:0] m_exp_addr = '0;
   logic [DW-1:0] m_exp_data = '0;

   int n40, nc0, n00, nother, pulses, addr_err, data_err, we_falls;
   int min_gap, min_rec, min_we, we_low, cyc, rise_prog, rise_c0;
   logic [DW-1:0] last_cmd, m_data;
   logic [AW-1:0] fall_addr;
   logic after40, prev_we = 1'b1, prev_oe = 1'b1;

   assign dq_in = (pulses >= m_need) ? m_data : ~m_data;

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (m_clr) begin
         n40 = 0; nc0 = 0; n00 = 0; nother = 0; pulses = 0;
         addr_err = 0; data_err = 0; we_falls = 0;
         min_gap = 1 << 30; min_rec = 1 << 30; min_we = 1 << 30;
         we_low = 0; rise_prog = 0; rise_c0 = 0;
         last_cmd = 8'hFF; m_data = 8'h00; after40 = 1'b0;
      end else begin
         if (!we_n) begin
            if (prev_we) begin
               we_low = 1; we_falls = we_falls + 1; fall_addr = fl_addr;
            end else we_low = we_low + 1;
         end
         if (!prev_we && we_n) begin
            if (we_low < min_we) min_we = we_low;
            if (!dq_oe) data_err = data_err + 1;
            if (after40) begin
               after40 = 1'b0;
               pulses = pulses + 1;
               m_data = dq_out;
               rise_prog = cyc;
               if (fall_addr != m_exp_addr || fl_addr != m_exp_addr) addr_err = addr_err + 1;
               if (dq_out != m_exp_data) data_err = data_err + 1;
            end else begin
               last_cmd = dq_out;
               case (dq_out)
                  8'h40: begin n40 = n40 + 1; after40 = 1'b1; end
                  8'hC0: begin
                     nc0 = nc0 + 1;
                     if (cyc - rise_prog < min_gap) min_gap = cyc - rise_prog;
                     rise_c0 = cyc;
                  end
                  8'h00: n00 = n00 + 1;
                  default: nother = nother + 1;
               endcase
            end
         end
         if (prev_oe && !oe_n) begin
            if (cyc - rise_c0 < min_rec) min_rec = cyc - rise_c0;
         end
      end
      prev_we = we_n;
      prev_oe = oe_n;
   end

   // ---------------- checking ----------------
   int checks = 0;
   int fails  = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   typedef struct packed {
      logic [16:0] a;
      logic [7:0]  d;
      logic [5:0]  need;
      logic        p;
      logic [4:0]  att;
   } vec_t;

   localparam int NV = 5;
   localparam vec_t VECS [0:NV-1] = '{
      '{a: 17'h00000, d: 8'h5A, need: 6'd1,  p: 1'b1, att: 5'd1},
      '{a: 17'h1FFFF, d: 8'h00, need: 6'd2,  p: 1'b1, att: 5'd2},
      '{a: 17'h0A5C3, d: 8'hC3, need: 6'd7,  p: 1'b1, att: 5'd7},
      '{a: 17'h12345, d: 8'h40, need: 6'd25, p: 1'b1, att: 5'd25},
      '{a: 17'h0F0F0, d: 8'h81, need: 6'd26, p: 1'b0, att: 5'd25}
   };

   task automatic run_req(input logic [AW-1:0] a, input logic [DW-1:0] d, input int need,
                          input bit exp_p, input int exp_att, input bit poke);
      int waited;
      @(negedge clk);
      m_need = need; m_exp_addr = a; m_exp_data = d; m_clr = 1'b1;
      @(negedge clk);
      m_clr = 1'b0;
      chk(ready == 1'b1, "R8 ready before request", ready, 1);
      req_valid = 1'b1; req_addr = a; req_data = d;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (30) @(negedge clk);
      chk(ready == 1'b0, "R8 ready low while busy", ready, 0);
      if (poke) begin
         req_valid = 1'b1; req_addr = a ^ 17'h15555; req_data = ~d;
         @(negedge clk);
         req_valid = 1'b0;
      end
      waited = 0;
      while (!done && waited < 20000) begin
         @(negedge clk);
         waited++;
      end
      chk(done == 1'b1, "R8 completion seen", done, 1);
      chk(pass == exp_p, "R6/R7 pass flag", pass, exp_p);
      chk(int'(attempts) == exp_att, "R6/R7 attempt count", attempts, exp_att);
      chk(n40 == exp_att, "R2 R7 program commands issued", n40, exp_att);
      chk(pulses == exp_att, "R2 data writes issued", pulses, exp_att);
      chk(nc0 == exp_att, "R5 verify commands issued", nc0, exp_att);
      chk(addr_err == 0, "R2 R9 address at strobe edges", addr_err, 0);
      chk(data_err == 0, "R3 R9 data on bus at rise", data_err, 0);
      chk(min_we >= WP, "R3 write strobe width", min_we, WP);
      chk(min_gap >= PULSE, "R4 program pulse gap", min_gap, PULSE);
      chk(min_rec >= RECOV, "R5 recovery before read", min_rec, RECOV);
      chk(last_cmd == 8'h00 && n00 == 1, "R8 read-mode write before done", last_cmd, 0);
      chk(nother == 0, "R2 no stray commands", nother, 0);
      @(negedge clk);
      chk(done == 1'b0, "R8 done is one cycle", done, 0);
      chk(ready == 1'b1, "R8 ready after done", ready, 1);
   endtask

   initial begin
      repeat (150000) @(negedge clk);
      fails++;
      checks++;
      $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
   end

   initial begin
      int falls_before;
      m_clr = 1'b1;
      repeat (4) @(negedge clk);
      // R1: reset state
      chk(ce_n && we_n && oe_n, "R1 strobes inactive in reset", {ce_n, we_n, oe_n}, 7);
      chk(dq_oe == 1'b0, "R1 data driver off in reset", dq_oe, 0);
      chk(ready == 1'b1 && done == 1'b0, "R1 ready/done in reset", {ready, done}, 2);
      rst_n = 1'b1;
      @(negedge clk);
      m_clr = 1'b0;
      chk(ce_n && we_n && oe_n && !dq_oe, "R1 idle after reset",
          {ce_n, we_n, oe_n, dq_oe}, 14);

      for (int i = 0; i < NV; i++)
         run_req(VECS[i].a, VECS[i].d, int'(VECS[i].need), VECS[i].p, int'(VECS[i].att), 1'b0);

      // R9: request while busy is ignored and does not start a later run
      run_req(17'h01234, 8'h3C, 3, 1'b1, 3, 1'b1);
      falls_before = we_falls;
      repeat (400) @(negedge clk);
      chk(we_falls == falls_before, "R9 no queued operation", we_falls, falls_before);
      chk(ready == 1'b1, "R9 stays idle", ready, 1);

      // R1: reset in the middle of an operation
      @(negedge clk);
      m_need = 5; m_clr = 1'b1;
      @(negedge clk);
      m_clr = 1'b0;
      req_valid = 1'b1; req_addr = 17'h00F00; req_data = 8'h11;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (150) @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk(ce_n && we_n && oe_n && !dq_oe, "R1 bus released by reset",
          {ce_n, we_n, oe_n, dq_oe}, 14);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ready == 1'b1 && done == 1'b0, "R1 idle after mid-run reset", {ready, done}, 2);

      // sequence still works after the interrupted run
      run_req(17'h1AAAA, 8'h96, 1, 1'b1, 1, 1'b0);

      summary();
      $finish;
   end

endmodule